// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block holds the interrupt controls for a bank of timer channels. Each channel has one enable bit and one status flag, and both sit in a single 32-bit register word. The timer channels supply one-cycle expiry pulses. Each pulse sets the status flag of its channel. The block drives one level interrupt line per channel, and that line is high while the channel's flag and its enable are both set.

Software reads the whole word on a read port that is always valid. It writes the word with a single-cycle write strobe. The enable field is stored exactly as it is written. The status field is write-one-to-clear. A flag is recorded on expiry even when its interrupt is masked, so software can poll flags without taking interrupts. When an expiry and a clearing write for the same channel arrive in the same cycle, the expiry wins and the flag stays set. In the default configuration the interrupt lines come from flops, so they cannot glitch. They follow flag-and-enable with one cycle of latency.

Top module: `tirq_ctrl`

## Requirements
- R1: After reset, rd_data reads 0 and every irq line is low.
- R2: A write loads the enable field, bits [NUM_CH-1:0] (default [4:0], bit i for channel i), from the same bits of wr_data. Without a write the enable field holds its value.
- R3: An expire pulse on channel i sets status bit NUM_CH+i (default bits [9:5]) at the next clock edge, whatever the enable bit of channel i holds.
- R4: A write with a 1 in status bit NUM_CH+i clears that flag. A 0 in that bit leaves the flag unchanged.
- R5: irq[i] is registered. It equals (status flag i AND enable bit i) as those bits stood one cycle earlier.
- R6: Clearing a status flag by a write drops the matching irq line one cycle after the flag clears.
- R7: If an expiry and a clearing write for the same channel fall in the same cycle, the flag is set after the edge.
- R8: Bits [DATA_W-1:2*NUM_CH] (default [31:10]) always read 0, and writes to them change nothing.
- R9: Writing 0 to the enable bit of a flagged channel drops its irq while the status flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire | input | NUM_CH | One-cycle expiry pulses, one bit for each channel |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register word: enables low, flags above them, zeros at the top |
| irq | output | NUM_CH | Level interrupt lines, one for each channel |

## Verification
The bench sets a flag on a masked channel to confirm that the enable does not gate the flag. A design that gated it would lose polled events. It races an expiry against a clearing write on the same channel, and a design that let the clear win would drop an interrupt. It writes zeros to the status field and checks that other flags survive, which catches a design that treats the field as plain data. It also writes to the unused upper bits, and masks a flagged channel to confirm that the line falls while the flag stays set. Every interrupt check is sampled at the one-cycle-delayed edge, so a design with combinational or two-cycle-late outputs fails.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
   localparam int unsigned DEF_NUM_CH = 5;
   localparam int unsigned DEF_DATA_W = 32;

   // bit position of the first status flag in the register word
   function automatic int unsigned flag_lsb(input int unsigned num_ch);
      return num_ch;
   endfunction
endpackage

// File: rtl/tirq_enable_reg.sv
module tirq_enable_reg #(
   parameter int unsigned NUM_CH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NUM_CH-1:0] load_val,
   output logic [NUM_CH-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= '0;
      else if (load) en_q <= load_val;
   end
endmodule

// File: rtl/tirq_status_flag.sv
module tirq_status_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_q
);
   // set has priority over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end
endmodule

// File: rtl/tirq_irq_out.sv
module tirq_irq_out #(
   parameter int unsigned NUM_CH  = 5,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flags,
   input  logic [NUM_CH-1:0] enables,
   output logic [NUM_CH-1:0] irq
);
   logic [NUM_CH-1:0] pend;
   assign pend = flags & enables;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= '0;
         else        irq <= pend;
      end
   end else begin : g_comb
      assign irq = pend;
   end
endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl
   import tirq_pkg::*;
#(
   parameter int unsigned NUM_CH  = DEF_NUM_CH,
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] expire,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] irq
);
   localparam int unsigned FLAG_LSB = flag_lsb(NUM_CH);
   localparam int unsigned USED_W   = 2 * NUM_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("tirq_ctrl: NUM_CH must be at least 1");
   end
   if (USED_W > DATA_W) begin : g_bad_w
      $error("tirq_ctrl: DATA_W too narrow for enables and flags");
   end

   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] clr_req;

   assign clr_req = {NUM_CH{wr_en}} & wr_data[FLAG_LSB +: NUM_CH];

   tirq_enable_reg #(.NUM_CH(NUM_CH)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en),
      .load_val (wr_data[NUM_CH-1:0]),
      .en_q     (en_q)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
      tirq_status_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (expire[ch]),
         .clr_i  (clr_req[ch]),
         .flag_q (flag_q[ch])
      );
   end

   tirq_irq_out #(.NUM_CH(NUM_CH), .REG_OUT(REG_OUT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flag_q),
      .enables (en_q),
      .irq     (irq)
   );

   always_comb begin
      rd_data                        = '0;
      rd_data[NUM_CH-1:0]            = en_q;
      rd_data[FLAG_LSB +: NUM_CH]    = flag_q;
   end
endmodule

module tirq_ctrl_chk #(
   parameter int unsigned NUM_CH  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] expire,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [NUM_CH-1:0] irq
);
   logic [NUM_CH-1:0] en_v, fl_v;
   assign en_v = rd_data[NUM_CH-1:0];
   assign fl_v = rd_data[NUM_CH +: NUM_CH];

   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> en_v == $past(wr_data[NUM_CH-1:0])); // R2
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_v)); // R2
   AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|expire) |=> (fl_v & $past(expire)) == $past(expire)); // R3
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (fl_v & $past(wr_data[NUM_CH +: NUM_CH] & ~expire)) == '0); // R4
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> (2 * NUM_CH)) == '0); // R8
   if (REG_OUT) begin : g_reg_chk
      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         irq == ($past(fl_v) & $past(en_v))); // R5
   end
endmodule

bind tirq_ctrl tirq_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .expire(expire), .wr_en(wr_en),
   .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

// File: tb/tirq_ctrl_tb.sv
module tirq_ctrl_tb;
   localparam int N = 5;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] expire = '0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic [N-1:0] irq;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] m_en = '0, m_st = '0, m_irq = '0;

   tirq_ctrl #(.NUM_CH(N), .DATA_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .expire(expire), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock with given stimulus; model updated from the requirements
   task automatic cycle(input logic [N-1:0] ex, input logic we, input logic [W-1:0] wd);
      expire  = ex;
      wr_en   = we;
      wr_data = wd;
      @(negedge clk);
      m_irq = m_st & m_en;
      if (we) begin
         m_en = wd[N-1:0];
         m_st = m_st & ~wd[N +: N];
      end
      m_st = m_st | ex;
      expire = '0;
      wr_en  = 1'b0;
      wr_data = '0;
   endtask

   function automatic logic [W-1:0] model_word();
      logic [W-1:0] v = '0;
      v[N-1:0]  = m_en;
      v[N +: N] = m_st;
      return v;
   endfunction

   task automatic check_all(input string req);
      check({req, " word"}, rd_data, model_word());
      check({req, " irq"}, W'(irq), W'(m_irq));
   endtask

   task automatic t_reset;
      check("R1 word", rd_data, '0);
      check("R1 irq", W'(irq), '0);
   endtask

   task automatic t_enable_load;
      cycle('0, 1'b1, 32'h0000_0015);
      check("R2 enables", W'(rd_data[N-1:0]), 32'h15);
      cycle('0, 1'b0, '0);
      check("R2 hold", W'(rd_data[N-1:0]), 32'h15);
   endtask

   task automatic t_masked_flag;
      cycle(5'b00010, 1'b0, '0);
      check("R3 masked flag set", W'(rd_data[N +: N]), 32'h02);
      cycle('0, 1'b0, '0);
      check_all("R3 masked no irq");
   endtask

   task automatic t_irq_latency;
      cycle(5'b00001, 1'b0, '0);
      check("R5 irq not yet", W'(irq[0]), 32'h0);
      cycle('0, 1'b0, '0);
      check("R5 irq after one cycle", W'(irq[0]), 32'h1);
      check_all("R5");
   endtask

   task automatic t_zero_write;
      cycle('0, 1'b1, 32'h0000_0015);
      check("R4 zeros keep flags", W'(rd_data[N +: N]), 32'h03);
      check_all("R4 zeros");
   endtask

   task automatic t_clear;
      cycle('0, 1'b1, 32'h0000_0035);
      check("R4 clear ch0", W'(rd_data[N +: N]), 32'h02);
      check("R6 irq still high", W'(irq[0]), 32'h1);
      cycle('0, 1'b0, '0);
      check("R6 irq dropped", W'(irq[0]), 32'h0);
      check_all("R6");
   endtask

   task automatic t_race;
      cycle(5'b00100, 1'b1, 32'h0000_0095);
      check("R7 expiry wins", W'(rd_data[N + 2]), 32'h1);
      cycle('0, 1'b0, '0);
      check_all("R7");
   endtask

   task automatic t_upper;
      cycle('0, 1'b1, 32'hFFFF_FC15);
      check("R8 upper zero", rd_data >> 10, '0);
      check_all("R8 low bits");
   endtask

   task automatic t_mask_flagged;
      cycle('0, 1'b0, '0);
      check("R9 irq2 high", W'(irq[2]), 32'h1);
      cycle('0, 1'b1, 32'h0000_0011);
      cycle('0, 1'b0, '0);
      check("R9 irq2 low", W'(irq[2]), 32'h0);
      check("R9 flag kept", W'(rd_data[N + 2]), 32'h1);
      check_all("R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_load();
      t_masked_flag();
      t_irq_latency();
      t_zero_write();
      t_clear();
      t_race();
      t_upper();
      t_mask_flagged();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule